// File: doc/BRIEF.md
# GPIO Bank with Set and Clear Aliases

This block controls a parameterised number of general-purpose pins from a simple 32-bit word bus. Pins are grouped 32 to a data word. For each group there is a direction word and an output-data word. Each of these words can be reached at three addresses. One address replaces the whole word. A second sets the bits written as 1. A third clears the bits written as 1. Software can therefore change single pins without a read-modify-write sequence.

Pin levels pass through a two-stage synchroniser and can be read back one bit per pin. Each pin also has a mode code of `MODE_BITS` bits that drives an external pin multiplexer. Several mode codes are packed into each 32-bit mode word, and mode words are written as whole words.

Word address map, with `g` the group and `k` the mode word index:

| Address | Register |
|---|---|
| 0x00+g | direction, whole-word write |
| 0x08+g | direction, set alias |
| 0x10+g | direction, clear alias |
| 0x18+g | output data, whole-word write |
| 0x20+g | output data, set alias |
| 0x28+g | output data, clear alias |
| 0x30+g | synchronised input levels, read-only |
| 0x40+k | mode words |

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every pin is an input (`pin_oe` = 0), every output value is 0 and every mode code is 0. Every register reads as 0 after reset.
- R2: A write to the direction set alias (0x08+g) sets exactly the direction bits that are 1 in the written word and leaves all other bits unchanged. A direction bit of 1 makes the pin an output, and `pin_oe` shows the change in the cycle after the write edge.
- R3: A write to the direction clear alias (0x10+g) clears exactly the direction bits that are 1 in the written word and leaves all other bits unchanged.
- R4: The output-data word has the same three aliases: whole-word at 0x18+g, set at 0x20+g and clear at 0x28+g. Its set and clear aliases follow the same write-one rule as R2 and R3. `pin_out` reflects the word in the cycle after the write edge.
- R5: A write to a whole-word alias (0x00+g or 0x18+g) replaces the whole word. A bus cycle that writes to none of the three aliases of a word leaves that word, and the pins it drives, unchanged.
- R6: Pin n belongs to group n/32 at bit n%32. Word bits that name pins at or above `NUM_PINS` always read 0, and writes to them are ignored.
- R7: A read returns its data on `bus_rdata` in the cycle after `bus_rd` is sampled, and shows the state before any write on the same edge. Reading the set or clear alias returns the same value as the whole-word alias. `bus_rdata` is 0 in any cycle that does not follow a read.
- R8: The input word at 0x30+g reports each pin level through two flops. A level applied before edge k is returned by a read sampled at edge k+2 or later, and is not returned by a read sampled at edge k+1. Writes to the input word have no effect.
- R9: Mode word k holds pins k*P to k*P+P-1, where P = 32/`MODE_BITS`. Pin n uses word n/P at bit offset (n%P)*`MODE_BITS`, and its code appears on `pin_mode[n*MODE_BITS +: MODE_BITS]` in the cycle after the write edge. Mode words are written whole. Field bits for pins that do not exist read 0 and ignore writes.
- R10: Writes to addresses that are not mapped (group or mode index out of range, or 0x38 to 0x3F) change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| bus_addr | input | 7 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| pin_out | output | NUM_PINS | Per-pin output value |
| pin_mode | output | NUM_PINS*MODE_BITS | Packed per-pin mode codes |

## Verification
Register writes take effect on the edge that samples `bus_wr`. The bench drives each write between falling edges and checks `pin_oe`, `pin_out` and `pin_mode` at the next falling edge, exactly one edge later. Read data is registered, so each read is compared at the falling edge after its sampling edge, against a model that has not yet applied any write from that edge. Pin levels take two edges to reach the input word. The bench therefore waits two edges after each random pin change, and a directed case also reads one edge early to confirm that the old level is still returned.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int ADDR_W = 7;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_DIR,
    RG_OUT,
    RG_IN,
    RG_MODE
  } region_e;

  typedef enum logic [1:0] {
    AL_NONE,
    AL_WHOLE,
    AL_SET,
    AL_CLR
  } alias_e;

  // bits of data word grp that name an existing pin
  function automatic logic [WORD_W-1:0] word_valid_mask(int num_pins, int grp);
    logic [WORD_W-1:0] m;
    for (int b = 0; b < WORD_W; b++) begin
      m[b] = ((grp * WORD_W + b) < num_pins);
    end
    return m;
  endfunction

  // bits of mode word w that belong to an existing pin's field
  function automatic logic [WORD_W-1:0] mode_valid_mask(int num_pins, int mbits, int w);
    logic [WORD_W-1:0] m;
    int per;
    per = WORD_W / mbits;
    for (int b = 0; b < WORD_W; b++) begin
      m[b] = (b < per * mbits) && ((w * per + b / mbits) < num_pins);
    end
    return m;
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_no = stage_q[1];

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int NGRP  = 2,
  parameter int NMODE = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output alias_e            kind,
  output logic [5:0]        index,
  output logic              hit
);

  always_comb begin
    region = RG_NONE;
    kind   = AL_NONE;
    index  = '0;
    hit    = 1'b0;
    if (addr[6]) begin
      region = RG_MODE;
      index  = addr[5:0];
      hit    = (int'(addr[5:0]) < NMODE);
    end else begin
      index = {3'b000, addr[2:0]};
      hit   = (int'(addr[2:0]) < NGRP);
      case (addr[5:3])
        3'd0: begin region = RG_DIR; kind = AL_WHOLE; end
        3'd1: begin region = RG_DIR; kind = AL_SET;   end
        3'd2: begin region = RG_DIR; kind = AL_CLR;   end
        3'd3: begin region = RG_OUT; kind = AL_WHOLE; end
        3'd4: begin region = RG_OUT; kind = AL_SET;   end
        3'd5: begin region = RG_OUT; kind = AL_CLR;   end
        3'd6: begin region = RG_IN; end
        default: begin region = RG_NONE; hit = 1'b0; end
      endcase
    end
  end

endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 44,
  parameter int NGRP     = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  alias_e                 kind,
  input  logic [5:0]             index,
  input  logic [WORD_W-1:0]      wdata,
  output logic [NGRP*WORD_W-1:0] q
);

  logic [NGRP*WORD_W-1:0] q_d;

  always_comb begin
    q_d = q;
    for (int g = 0; g < NGRP; g++) begin
      if (index == 6'(g)) begin
        case (kind)
          AL_WHOLE: q_d[g*WORD_W +: WORD_W] = wdata & word_valid_mask(NUM_PINS, g);
          AL_SET:   q_d[g*WORD_W +: WORD_W] = (q[g*WORD_W +: WORD_W] | wdata)
                                              & word_valid_mask(NUM_PINS, g);
          AL_CLR:   q_d[g*WORD_W +: WORD_W] = q[g*WORD_W +: WORD_W] & ~wdata;
          default:  q_d[g*WORD_W +: WORD_W] = q[g*WORD_W +: WORD_W];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en) begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/gpio_mode_regs.sv
module gpio_mode_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS  = 44,
  parameter int MODE_BITS = 4,
  parameter int NMODE     = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [5:0]              index,
  input  logic [WORD_W-1:0]       wdata,
  output logic [NMODE*WORD_W-1:0] q
);

  logic [NMODE*WORD_W-1:0] q_d;

  always_comb begin
    q_d = q;
    for (int k = 0; k < NMODE; k++) begin
      if (index == 6'(k)) begin
        q_d[k*WORD_W +: WORD_W] = wdata & mode_valid_mask(NUM_PINS, MODE_BITS, k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en) begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 44
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS  = 44,
  parameter int MODE_BITS = 4
) (
  input  logic                          clk,
  input  logic                          rst_ni,
  input  logic [6:0]                    bus_addr,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  input  logic [NUM_PINS-1:0]           pin_in,
  output logic [NUM_PINS-1:0]           pin_oe,
  output logic [NUM_PINS-1:0]           pin_out,
  output logic [NUM_PINS*MODE_BITS-1:0] pin_mode
);

  localparam int PPM   = WORD_W / MODE_BITS;
  localparam int NGRP  = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int NMODE = (NUM_PINS + PPM - 1) / PPM;

  logic                    rst_n;
  region_e                 region;
  alias_e                  kind;
  logic [5:0]              index;
  logic                    hit;
  logic                    wr_dir;
  logic                    wr_out;
  logic                    wr_mode;
  logic [NGRP*WORD_W-1:0]  dir_q;
  logic [NGRP*WORD_W-1:0]  out_q;
  logic [NUM_PINS-1:0]     in_q;
  logic [NGRP*WORD_W-1:0]  in_pad;
  logic [NMODE*WORD_W-1:0] mode_q;
  logic [WORD_W-1:0]       rd_word;
  logic [WORD_W-1:0]       rdata_d;
  logic [WORD_W-1:0]       rdata_q;

  gpio_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  gpio_addr_decode #(
    .NGRP  (NGRP),
    .NMODE (NMODE)
  ) u_dec (
    .addr   (bus_addr),
    .region (region),
    .kind   (kind),
    .index  (index),
    .hit    (hit)
  );

  assign wr_dir  = bus_wr && hit && (region == RG_DIR);
  assign wr_out  = bus_wr && hit && (region == RG_OUT);
  assign wr_mode = bus_wr && hit && (region == RG_MODE);

  gpio_alias_reg #(
    .NUM_PINS (NUM_PINS),
    .NGRP     (NGRP)
  ) u_dir (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_dir),
    .kind  (kind),
    .index (index),
    .wdata (bus_wdata),
    .q     (dir_q)
  );

  gpio_alias_reg #(
    .NUM_PINS (NUM_PINS),
    .NGRP     (NGRP)
  ) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_out),
    .kind  (kind),
    .index (index),
    .wdata (bus_wdata),
    .q     (out_q)
  );

  gpio_mode_regs #(
    .NUM_PINS  (NUM_PINS),
    .MODE_BITS (MODE_BITS),
    .NMODE     (NMODE)
  ) u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_mode),
    .index (index),
    .wdata (bus_wdata),
    .q     (mode_q)
  );

  gpio_in_sync #(
    .W (NUM_PINS)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (in_q)
  );

  assign in_pad = (NGRP*WORD_W)'(in_q);

  // read selection
  always_comb begin
    rd_word = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (index == 6'(g)) begin
        case (region)
          RG_DIR:  rd_word = dir_q[g*WORD_W +: WORD_W];
          RG_OUT:  rd_word = out_q[g*WORD_W +: WORD_W];
          RG_IN:   rd_word = in_pad[g*WORD_W +: WORD_W];
          default: ;
        endcase
      end
    end
    for (int k = 0; k < NMODE; k++) begin
      if ((region == RG_MODE) && (index == 6'(k))) begin
        rd_word = mode_q[k*WORD_W +: WORD_W];
      end
    end
    if (!hit) begin
      rd_word = '0;
    end
  end

  assign rdata_d = bus_rd ? rd_word : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign pin_oe    = dir_q[NUM_PINS-1:0];
  assign pin_out   = out_q[NUM_PINS-1:0];

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_mode_pin
    assign pin_mode[n*MODE_BITS +: MODE_BITS] =
      mode_q[(n / PPM) * WORD_W + (n % PPM) * MODE_BITS +: MODE_BITS];
  end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS  = 44,
  parameter int MODE_BITS = 4
) (
  input logic                                              clk,
  input logic                                              rst_n,
  input logic [6:0]                                        bus_addr,
  input logic                                              bus_wr,
  input logic                                              bus_rd,
  input logic [31:0]                                       bus_wdata,
  input logic [31:0]                                       bus_rdata,
  input logic [NUM_PINS-1:0]                               pin_in,
  input logic [NUM_PINS-1:0]                               pin_oe,
  input logic [NUM_PINS-1:0]                               pin_out,
  input logic [NUM_PINS*MODE_BITS-1:0]                     pin_mode,
  input logic [((NUM_PINS+WORD_W-1)/WORD_W)*WORD_W-1:0]    dir_q,
  input logic [((NUM_PINS+WORD_W-1)/WORD_W)*WORD_W-1:0]    out_q,
  input logic [NUM_PINS-1:0]                               in_q
);

  localparam int NGRP = (NUM_PINS + WORD_W - 1) / WORD_W;

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= 2'd0;
    end else if (since_rst != 2'd3) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [31:0] VM = word_valid_mask(NUM_PINS, g);

    AST_DIR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 7'(8 + g)) |=>
        (((dir_q[g*32 +: 32] & $past(bus_wdata) & VM) == ($past(bus_wdata) & VM)) &&
         ((dir_q[g*32 +: 32] & ~$past(bus_wdata)) == ($past(dir_q[g*32 +: 32]) & ~$past(bus_wdata))))); // R2

    AST_DIR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 7'(16 + g)) |=>
        (((dir_q[g*32 +: 32] & $past(bus_wdata)) == 32'h0) &&
         ((dir_q[g*32 +: 32] & ~$past(bus_wdata)) == ($past(dir_q[g*32 +: 32]) & ~$past(bus_wdata))))); // R3

    AST_OUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 7'(32 + g)) |=>
        (((out_q[g*32 +: 32] & $past(bus_wdata) & VM) == ($past(bus_wdata) & VM)) &&
         ((out_q[g*32 +: 32] & ~$past(bus_wdata)) == ($past(out_q[g*32 +: 32]) & ~$past(bus_wdata))))); // R4

    AST_OUT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 7'(40 + g)) |=>
        (((out_q[g*32 +: 32] & $past(bus_wdata)) == 32'h0) &&
         ((out_q[g*32 +: 32] & ~$past(bus_wdata)) == ($past(out_q[g*32 +: 32]) & ~$past(bus_wdata))))); // R4
  end

  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr[6:3] <= 4'd2) |=> $stable(pin_oe)); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr[6:3] >= 4'd3 && bus_addr[6:3] <= 4'd5) |=> $stable(pin_out)); // R5

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr[6]) |=> $stable(pin_mode)); // R9

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> (bus_rdata == 32'h0)); // R7

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (in_q == $past(pin_in, 2))); // R8

endmodule

bind gpio_bank gpio_bank_chk #(
  .NUM_PINS  (NUM_PINS),
  .MODE_BITS (MODE_BITS)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_in    (pin_in),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .pin_mode  (pin_mode),
  .dir_q     (dir_q),
  .out_q     (out_q),
  .in_q      (in_q)
);

// File: tb/gpio_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_tb_top;

  localparam int NP    = 44;
  localparam int MB    = 4;
  localparam int PPM   = 32 / MB;
  localparam int NGRP  = (NP + 31) / 32;
  localparam int NMODE = (NP + PPM - 1) / PPM;

  logic              clk;
  logic              rst_ni;
  logic [6:0]        bus_addr;
  logic              bus_wr;
  logic              bus_rd;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [NP-1:0]     pin_in;
  logic [NP-1:0]     pin_oe;
  logic [NP-1:0]     pin_out;
  logic [NP*MB-1:0]  pin_mode;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_dir  [NGRP];
  logic [31:0] m_out  [NGRP];
  logic [31:0] m_mode [NMODE];

  gpio_bank #(.NUM_PINS(NP), .MODE_BITS(MB)) dut_i (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .pin_mode  (pin_mode)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [31:0] vmask(int g);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = (g * 32 + b < NP);
    return m;
  endfunction

  function automatic logic [31:0] mmask(int w);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = (b / MB < PPM) && (w * PPM + b / MB < NP);
    return m;
  endfunction

  function automatic logic [31:0] pin_word(int g);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) r[b] = (g * 32 + b < NP) ? pin_in[g * 32 + b] : 1'b0;
    return r;
  endfunction

  function automatic logic [NP-1:0] exp_oe();
    logic [NP-1:0] r;
    for (int n = 0; n < NP; n++) r[n] = m_dir[n / 32][n % 32];
    return r;
  endfunction

  function automatic logic [NP-1:0] exp_out();
    logic [NP-1:0] r;
    for (int n = 0; n < NP; n++) r[n] = m_out[n / 32][n % 32];
    return r;
  endfunction

  function automatic logic [NP*MB-1:0] exp_mode();
    logic [NP*MB-1:0] r;
    for (int n = 0; n < NP; n++)
      for (int b = 0; b < MB; b++)
        r[n * MB + b] = m_mode[n / PPM][(n % PPM) * MB + b];
    return r;
  endfunction

  function automatic logic [31:0] exp_read(logic [6:0] a);
    int g;
    if (a[6]) return (int'(a[5:0]) < NMODE) ? m_mode[a[5:0]] : 32'h0;
    g = int'(a[2:0]);
    if (g >= NGRP) return 32'h0;
    case (a[5:3])
      3'd0, 3'd1, 3'd2: return m_dir[g];
      3'd3, 3'd4, 3'd5: return m_out[g];
      3'd6:             return pin_word(g);
      default:          return 32'h0;
    endcase
  endfunction

  function automatic void model_write(logic [6:0] a, logic [31:0] d);
    int g;
    if (a[6]) begin
      if (int'(a[5:0]) < NMODE) m_mode[a[5:0]] = d & mmask(int'(a[5:0]));
      return;
    end
    g = int'(a[2:0]);
    if (g >= NGRP) return;
    case (a[5:3])
      3'd0: m_dir[g] = d & vmask(g);
      3'd1: m_dir[g] = (m_dir[g] | d) & vmask(g);
      3'd2: m_dir[g] = m_dir[g] & ~d;
      3'd3: m_out[g] = d & vmask(g);
      3'd4: m_out[g] = (m_out[g] | d) & vmask(g);
      3'd5: m_out[g] = m_out[g] & ~d;
      default: ;
    endcase
  endfunction

  task automatic chk(input string req, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
    d        = bus_rdata;
  endtask

  task automatic read_chk(input string req, input logic [6:0] a);
    logic [31:0] d;
    logic [31:0] e;
    e = exp_read(a);
    bus_read(a, d);
    chk(req, d, e);
  endtask

  task automatic pins_chk();
    chk("R2 R3 R5 pin_oe", pin_oe, exp_oe());
    chk("R4 pin_out", pin_out, exp_out());
    chk("R9 pin_mode", pin_mode, exp_mode());
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] old_word;
    void'($urandom(32'h5EED_1234));
    rst_ni = 1'b0;
    bus_addr = '0;
    bus_wr = 1'b0;
    bus_rd = 1'b0;
    bus_wdata = '0;
    pin_in = '0;
    for (int g = 0; g < NGRP; g++) begin m_dir[g] = '0; m_out[g] = '0; end
    for (int k = 0; k < NMODE; k++) m_mode[k] = '0;

    repeat (3) @(negedge clk);
    // R1: outputs held at zero while in reset
    chk("R1 oe in reset", pin_oe, '0);
    chk("R1 out in reset", pin_out, '0);
    chk("R1 mode in reset", pin_mode, '0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    pins_chk();
    for (int g = 0; g < NGRP; g++) begin
      read_chk("R1 dir reset", 7'(g));
      read_chk("R1 out reset", 7'(8'h18 + g));
    end
    for (int k = 0; k < NMODE; k++) read_chk("R1 mode reset", 7'(8'h40 + k));

    // R2: set alias only touches ones
    bus_write(7'h08, 32'h0000_00F0);
    bus_write(7'h08, 32'h0000_0003);
    chk("R2 set accumulates", pin_oe[31:0], 32'h0000_00F3);
    // R3: clear alias only touches ones
    bus_write(7'h10, 32'h0000_0030);
    chk("R3 clear", pin_oe[31:0], 32'h0000_00C3);
    read_chk("R3 readback", 7'h00);
    // R7: aliases read back current value
    bus_read(7'h08, d);
    chk("R7 set alias read", d, 32'h0000_00C3);
    bus_read(7'h10, d);
    chk("R7 clear alias read", d, 32'h0000_00C3);
    // R5: whole-word write replaces
    bus_write(7'h00, 32'hA5A5_A5A5);
    chk("R5 whole word", pin_oe[31:0], 32'hA5A5_A5A5);
    // R4: output aliases
    bus_write(7'h18, 32'h0F0F_0000);
    bus_write(7'h20, 32'h0000_0011);
    bus_write(7'h28, 32'h0100_0001);
    chk("R4 out aliases", pin_out[31:0], 32'h0E0F_0010);
    pins_chk();
    // R6: upper group, nonexistent bits
    bus_write(7'h09, 32'hFFFF_FFFF);
    chk("R6 top group oe", pin_oe[NP-1:32], {(NP-32){1'b1}});
    bus_read(7'h01, d);
    chk("R6 pad bits read zero", d, 32'h0000_0FFF);
    bus_write(7'h01, 32'h0000_0002);
    chk("R6 pin33 mapping", pin_oe[NP-1:32], (NP-32)'(2));
    // R9: mode fields and masking
    bus_write(7'h45, 32'hFFFF_FFFF);
    bus_read(7'h45, d);
    chk("R9 partial mode word", d, 32'h0000_FFFF);
    chk("R9 pin43 mode", pin_mode[43*MB +: MB], 4'hF);
    bus_read(7'h40, old_word);
    bus_write(7'h40, (old_word & ~32'h0000_00F0) | 32'h0000_00A0);
    chk("R9 pin1 mode", pin_mode[1*MB +: MB], 4'hA);
    pins_chk();
    // R8: two-flop input path
    @(negedge clk);
    pin_in = 44'hABC_1234_5678;
    bus_read(7'h30, d);
    chk("R8 too early", d, 32'h0);
    bus_read(7'h30, d);
    chk("R8 visible", d, 32'h1234_5678);
    read_chk("R8 upper", 7'h31);
    bus_write(7'h30, 32'hFFFF_FFFF);
    read_chk("R8 write ignored", 7'h30);
    pins_chk();
    // R10: unmapped addresses
    bus_write(7'h38, 32'hFFFF_FFFF);
    bus_write(7'h02, 32'hFFFF_FFFF);
    bus_write(7'h7F, 32'hFFFF_FFFF);
    pins_chk();
    read_chk("R10 hole read", 7'h38);
    read_chk("R10 mode oob read", 7'h7F);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [6:0] a;
      op = int'($urandom % 8);
      if (op < 6) begin
        a = 7'(op * 8 + int'($urandom % 4));
        bus_write(a, $urandom);
      end else if (op == 6) begin
        a = 7'(8'h40 + ($urandom % 8));
        bus_write(a, $urandom);
      end else begin
        @(negedge clk);
        pin_in = {$urandom, $urandom};
        @(negedge clk);
        @(negedge clk);
      end
      pins_chk();
      a = 7'($urandom % 128);
      read_chk("R7 R10 random read", a);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule